// File: doc/BRIEF.md
# Parallel PRBS Generator and Self-Synchronizing Checker

This block produces a pseudorandom test pattern several bits at a time and checks such a pattern on the receive side. The generator holds a Fibonacci shift register. In every enabled cycle it advances that register by `WORD_W` serial steps at once and presents the `WORD_W` produced bits as one parallel word. The bit produced first in time is placed in the word's MSB. A parameter selects the pattern. The 31-stage pattern uses the polynomial x^31 + x^28 + 1 and inverts its output bits. The 9-stage pattern uses x^9 + x^5 + 1 and does not invert its output.

The checker needs no seed. It rebuilds the sequence from the bits it has already received. For each incoming bit it forms a prediction by XORing two earlier received bits. Any bit that differs from its prediction is flagged in an error word, at the same bit position as the bit that caused it. The checker controller has three states:
- `CHK_FILL` waits while its history register fills.
- `CHK_HUNT` counts clean bits until the pattern is trusted.
- `CHK_LOCK` is the locked state.

The transitions are:
- fill done: `CHK_FILL` to `CHK_HUNT`, after ceil(REG_W/WORD_W) checked words.
- lock: `CHK_HUNT` to `CHK_LOCK`.
- loss: `CHK_LOCK` to `CHK_HUNT`.

A saturating counter accumulates the flagged errors.

Top module: `prbs_txrx`

## Requirements
- R1: While reset is high and in the first cycle after it, gen_data, chk_err_bits and err_count are zero and locked is low. The generator register resets to all ones.
- R2: Each cycle with gen_en high, gen_data takes the next WORD_W bits of the sequence, with the earliest bit in bit WORD_W-1. Each serial step computes f = s[REG_W-1] XOR s[TAP] and shifts f into bit 0, and f is the produced bit. For PRBS_SEL=1: REG_W=31, TAP=27, and output bits are inverted. For PRBS_SEL=0: REG_W=9, TAP=4, with no inversion.
- R3: A cycle with seed_load high loads seed_value into the generator register, with all ones substituted for an all-zero value. Loading takes priority over gen_en, and gen_data holds in that cycle.
- R4: With gen_en low and seed_load low, gen_data and the generator register hold, so the next enabled word continues the sequence without a gap.
- R5: Each chk_en cycle, the checker first undoes the output inversion of every received bit. It then compares each bit with the XOR of the bits received REG_W and TAP+1 bits earlier. It sets chk_err_bits at each differing position, with no seed needed.
- R6: The first ceil(REG_W/WORD_W) chk_en words after reset (state CHK_FILL) leave chk_err_bits zero and err_count unchanged, but still fill the history.
- R7: Outside CHK_FILL, err_count adds the number of flagged bits of every checked word and saturates at 2^CNT_W-1.
- R8: In CHK_HUNT, a clean word adds WORD_W to a run count and a word with any error clears it. locked rises after the clean word that brings the run to at least LOCK_BITS (64).
- R9: In CHK_LOCK, a word with at least DROP_ERRS (8) flagged bits returns to CHK_HUNT and drops locked. Words with fewer flagged bits keep lock.
- R10: A single flipped bit in an otherwise correct stream is flagged exactly three times: at its own position, and TAP+1 and REG_W bits later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_en | input | 1 | Advance the generator by one word |
| seed_load | input | 1 | Load seed_value into the generator register |
| seed_value | input | REG_W | Seed; zero is replaced by all ones |
| gen_data | output | WORD_W | Generated word, earliest bit in MSB |
| chk_en | input | 1 | chk_data holds a word to check |
| chk_data | input | WORD_W | Received word, earliest bit in MSB |
| chk_err_bits | output | WORD_W | Positions of mispredicted bits of the last checked word |
| err_count | output | CNT_W | Saturating total of flagged bits |
| locked | output | 1 | Checker is in CHK_LOCK |

## Verification
The bench first loads an all-zero seed. A design that failed to substitute all ones would emit a constant word forever. Garbage words are sent during the fill phase. A checker that reported errors before its history was full would raise chk_err_bits and err_count at once. The bench injects a single bit flip while locked and expects exactly three flagged errors with lock held. Wrong tap indices would give a different count, and a threshold slip would drop lock. A fully inverted word must produce WORD_W errors and force the loss transition. Long garbage runs must pin the counter at its maximum rather than wrap. The checker must also relock from clean data with no reseed, which proves it is self-synchronizing.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    typedef enum logic [1:0] {
        CHK_FILL = 2'd0,
        CHK_HUNT = 2'd1,
        CHK_LOCK = 2'd2
    } chk_state_e;

    // register length for a pattern selector (0: 9-stage, 1: 31-stage)
    function automatic int reg_width(input int sel);
        return (sel != 0) ? 31 : 9;
    endfunction

    // index of the inner feedback tap (exponent minus one)
    function automatic int tap_index(input int sel);
        return (sel != 0) ? 27 : 4;
    endfunction

    function automatic bit out_inverted(input int sel);
        return (sel != 0);
    endfunction

endpackage

// File: rtl/prbs_step.sv
// Unrolled WORD_W-step Fibonacci update, purely combinational.
// FEED_FWD=0: feedback form, produced bit = taps ^ injected bit.
// FEED_FWD=1: feed-forward form, received bits fill the register and
//             bits_out is received ^ predicted.
module prbs_step #(
    parameter int REG_W    = 31,
    parameter int TAP      = 27,
    parameter int WORD_W   = 16,
    parameter bit FEED_FWD = 1'b0
) (
    input  logic [REG_W-1:0]  st_in,
    input  logic [WORD_W-1:0] bits_in,
    output logic [REG_W-1:0]  st_out,
    output logic [WORD_W-1:0] bits_out
);

    logic [REG_W-1:0] walk;

    if (FEED_FWD) begin : g_forward
        always_comb begin
            logic pred;
            walk     = st_in;
            bits_out = '0;
            for (int k = 0; k < WORD_W; k++) begin
                pred                 = walk[REG_W-1] ^ walk[TAP];
                bits_out[WORD_W-1-k] = bits_in[WORD_W-1-k] ^ pred;
                walk                 = {walk[REG_W-2:0], bits_in[WORD_W-1-k]};
            end
            st_out = walk;
        end
    end else begin : g_feedback
        always_comb begin
            logic fb;
            walk     = st_in;
            bits_out = '0;
            for (int k = 0; k < WORD_W; k++) begin
                fb                   = walk[REG_W-1] ^ walk[TAP] ^ bits_in[WORD_W-1-k];
                bits_out[WORD_W-1-k] = fb;
                walk                 = {walk[REG_W-2:0], fb};
            end
            st_out = walk;
        end
    end

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
    parameter int REG_W  = 31,
    parameter int TAP    = 27,
    parameter int WORD_W = 16,
    parameter bit INVERT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [REG_W-1:0]  seed,
    output logic [WORD_W-1:0] data
);

    logic [REG_W-1:0]  state_q;
    logic [REG_W-1:0]  state_step;
    logic [WORD_W-1:0] bits_step;
    logic [WORD_W-1:0] data_q;

    prbs_step #(
        .REG_W    (REG_W),
        .TAP      (TAP),
        .WORD_W   (WORD_W),
        .FEED_FWD (1'b0)
    ) u_step (
        .st_in    (state_q),
        .bits_in  ({WORD_W{1'b0}}),
        .st_out   (state_step),
        .bits_out (bits_step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '1;
            data_q  <= '0;
        end else if (load) begin
            state_q <= (seed == '0) ? '1 : seed;
        end else if (en) begin
            state_q <= state_step;
            data_q  <= bits_step ^ {WORD_W{INVERT}};
        end
    end

    assign data = data_q;

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);                                          // R3

    AST_ZERO_SEED_SUB: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> (state_q == '1));               // R3

    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en || load) |=> $stable(data_q));                      // R4

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk #(
    parameter int REG_W     = 31,
    parameter int TAP       = 27,
    parameter int WORD_W    = 16,
    parameter bit INVERT    = 1'b1,
    parameter int CNT_W     = 16,
    parameter int LOCK_BITS = 64,
    parameter int DROP_ERRS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] err_bits,
    output logic [CNT_W-1:0]  err_count,
    output logic              locked
);
    import prbs_pkg::*;

    localparam int FILL_WORDS = (REG_W + WORD_W - 1) / WORD_W;
    localparam int FILL_W     = $clog2(FILL_WORDS + 1);
    localparam int RUN_W      = $clog2(LOCK_BITS + WORD_W + 1);
    localparam int POP_W      = $clog2(WORD_W + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(FILL_WORDS - 1);
    localparam logic [RUN_W-1:0]  RUN_STEP  = RUN_W'(WORD_W);
    localparam logic [RUN_W-1:0]  RUN_GOAL  = RUN_W'(LOCK_BITS);
    localparam logic [POP_W-1:0]  DROP_MIN  = POP_W'(DROP_ERRS);

    chk_state_e         state_q, state_d;
    logic [REG_W-1:0]   hist_q, hist_step;
    logic [WORD_W-1:0]  miss;
    logic [WORD_W-1:0]  err_q;
    logic [FILL_W-1:0]  fill_q;
    logic [RUN_W-1:0]   run_q;
    logic [RUN_W-1:0]   run_sum;
    logic [CNT_W-1:0]   cnt_q, cnt_next;
    logic [CNT_W:0]     cnt_sum;
    logic [POP_W-1:0]   pop;
    logic               word_clean, word_heavy;

    prbs_step #(
        .REG_W    (REG_W),
        .TAP      (TAP),
        .WORD_W   (WORD_W),
        .FEED_FWD (1'b1)
    ) u_step (
        .st_in    (hist_q),
        .bits_in  (din ^ {WORD_W{INVERT}}),
        .st_out   (hist_step),
        .bits_out (miss)
    );

    always_comb begin
        pop = '0;
        for (int i = 0; i < WORD_W; i++) begin
            pop = pop + POP_W'(miss[i]);
        end
    end

    assign word_clean = (pop == '0);
    assign word_heavy = (pop >= DROP_MIN);
    assign run_sum    = run_q + RUN_STEP;
    assign cnt_sum    = {1'b0, cnt_q} + (CNT_W+1)'(pop);
    assign cnt_next   = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CHK_FILL;
        else     state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (en) begin
            unique case (state_q)
                CHK_FILL: if (fill_q == FILL_LAST)                 state_d = CHK_HUNT;
                CHK_HUNT: if (word_clean && run_sum >= RUN_GOAL)   state_d = CHK_LOCK;
                CHK_LOCK: if (word_heavy)                          state_d = CHK_HUNT;
                default:                                           state_d = CHK_FILL;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
            run_q  <= '0;
            err_q  <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            hist_q <= hist_step;
            unique case (state_q)
                CHK_FILL: begin
                    fill_q <= fill_q + 1'b1;
                    err_q  <= '0;
                end
                CHK_HUNT: begin
                    err_q <= miss;
                    cnt_q <= cnt_next;
                    run_q <= word_clean ? run_sum : '0;
                end
                CHK_LOCK: begin
                    err_q <= miss;
                    cnt_q <= cnt_next;
                    run_q <= '0;
                end
                default: begin
                    err_q <= '0;
                end
            endcase
        end
    end

    assign err_bits  = err_q;
    assign err_count = cnt_q;
    assign locked    = (state_q == CHK_LOCK);

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == CHK_FILL) |-> (err_q == '0 && cnt_q == '0));   // R6

    AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q >= $past(cnt_q)));                         // R7

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) |=> (cnt_q == '1));                          // R7

    AST_LOCK_ON_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (err_q == '0));                          // R8

    AST_DROP_ON_HEAVY: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($countones(err_q) >= DROP_ERRS));       // R9

endmodule

// File: rtl/prbs_txrx.sv
module prbs_txrx #(
    parameter int PRBS_SEL  = 1,
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 16,
    parameter int LOCK_BITS = 64,
    parameter int DROP_ERRS = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   gen_en,
    input  logic                                   seed_load,
    input  logic [prbs_pkg::reg_width(PRBS_SEL)-1:0] seed_value,
    output logic [WORD_W-1:0]                      gen_data,
    input  logic                                   chk_en,
    input  logic [WORD_W-1:0]                      chk_data,
    output logic [WORD_W-1:0]                      chk_err_bits,
    output logic [CNT_W-1:0]                       err_count,
    output logic                                   locked
);

    localparam int REG_W  = prbs_pkg::reg_width(PRBS_SEL);
    localparam int TAP    = prbs_pkg::tap_index(PRBS_SEL);
    localparam bit INVERT = prbs_pkg::out_inverted(PRBS_SEL);

    prbs_gen #(
        .REG_W  (REG_W),
        .TAP    (TAP),
        .WORD_W (WORD_W),
        .INVERT (INVERT)
    ) u_gen (
        .clk  (clk),
        .rst  (rst),
        .en   (gen_en),
        .load (seed_load),
        .seed (seed_value),
        .data (gen_data)
    );

    prbs_chk #(
        .REG_W     (REG_W),
        .TAP       (TAP),
        .WORD_W    (WORD_W),
        .INVERT    (INVERT),
        .CNT_W     (CNT_W),
        .LOCK_BITS (LOCK_BITS),
        .DROP_ERRS (DROP_ERRS)
    ) u_chk (
        .clk       (clk),
        .rst       (rst),
        .en        (chk_en),
        .din       (chk_data),
        .err_bits  (chk_err_bits),
        .err_count (err_count),
        .locked    (locked)
    );

endmodule

// File: tb/tb_prbs_txrx.sv
`timescale 1ns/1ps
module tb_prbs_txrx;

    logic        clk = 1'b0;
    logic        rst;
    logic        gen_en, seed_load, chk_en;
    logic [30:0] seed_value;
    logic [15:0] chk_data;
    logic [15:0] gen_data, chk_err_bits;
    logic [7:0]  err_count;
    logic        locked;

    logic [8:0]  seed9;
    logic [7:0]  chk9_data, gen9_data, err9_bits;
    logic [7:0]  cnt9;
    logic        locked9;

    always #2 clk = ~clk;

    prbs_txrx #(.PRBS_SEL(1), .WORD_W(16), .CNT_W(8)) dut (
        .clk(clk), .rst(rst), .gen_en(gen_en), .seed_load(seed_load),
        .seed_value(seed_value), .gen_data(gen_data), .chk_en(chk_en),
        .chk_data(chk_data), .chk_err_bits(chk_err_bits),
        .err_count(err_count), .locked(locked));

    prbs_txrx #(.PRBS_SEL(0), .WORD_W(8), .CNT_W(8)) dut9 (
        .clk(clk), .rst(rst), .gen_en(gen_en), .seed_load(seed_load),
        .seed_value(seed9), .gen_data(gen9_data), .chk_en(gen_en),
        .chk_data(chk9_data), .chk_err_bits(err9_bits),
        .err_count(cnt9), .locked(locked9));

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [63:0] m_gen = 64'h7fffffff;
    logic [15:0] m_data = '0;
    logic [63:0] m_g9 = 64'h1ff;
    logic [7:0]  m_d9 = '0;
    logic [30:0] m_hist = '0;
    int m_st = 0, m_fill = 0, m_run = 0, m_cnt = 0;
    logic [15:0] m_eb = '0;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic gen_model(input int w, input int tap, input bit inv, input int ww,
                             inout logic [63:0] s, output logic [63:0] word);
        logic fb;
        logic [63:0] msk = (64'd1 << w) - 1;
        word = '0;
        for (int k = 0; k < ww; k++) begin
            fb = s[w-1] ^ s[tap];
            word[ww-1-k] = fb ^ inv;
            s = ((s << 1) | 64'(fb)) & msk;
        end
    endtask

    task automatic chk_model(input logic [15:0] cin);
        logic [15:0] errs = '0;
        logic r, pred;
        int n;
        for (int k = 0; k < 16; k++) begin
            r = cin[15-k] ^ 1'b1;
            pred = m_hist[30] ^ m_hist[27];
            errs[15-k] = r ^ pred;
            m_hist = {m_hist[29:0], r};
        end
        n = $countones(errs);
        case (m_st)
            0: begin
                m_eb = '0; m_fill++;
                if (m_fill == 2) m_st = 1;
            end
            1: begin
                m_eb = errs; m_cnt = (m_cnt + n > 255) ? 255 : m_cnt + n;
                if (n == 0) m_run += 16; else m_run = 0;
                if (m_run >= 64) m_st = 2;
            end
            default: begin
                m_eb = errs; m_cnt = (m_cnt + n > 255) ? 255 : m_cnt + n;
                m_run = 0;
                if (n >= 8) m_st = 1;
            end
        endcase
    endtask

    // one clock: drive at the falling edge, advance the model, compare at next fall
    task automatic tick(input logic en, input logic ld, input logic [30:0] sd,
                        input logic cen, input logic [15:0] cin);
        logic [63:0] w;
        gen_en = en; seed_load = ld; seed_value = sd; seed9 = sd[8:0];
        chk_en = cen; chk_data = cin; chk9_data = gen9_data;
        if (ld) begin
            m_gen = (sd == 0) ? 64'h7fffffff : 64'(sd);
            m_g9  = (sd[8:0] == 0) ? 64'h1ff : 64'(sd[8:0]);
        end else if (en) begin
            gen_model(31, 27, 1'b1, 16, m_gen, w); m_data = w[15:0];
            gen_model(9, 4, 1'b0, 8, m_g9, w);     m_d9 = w[7:0];
        end
        if (cen) chk_model(cin);
        @(negedge clk);
        check(gen_data == m_data, "R2/R3/R4 gen_data", 64'(gen_data), 64'(m_data));
        check(gen9_data == m_d9, "R2 gen_data 9-stage", 64'(gen9_data), 64'(m_d9));
        check(chk_err_bits == m_eb, "R5/R10 chk_err_bits", 64'(chk_err_bits), 64'(m_eb));
        check(int'(err_count) == m_cnt, "R7 err_count", 64'(err_count), 64'(m_cnt));
        check(locked == (m_st == 2), "R8/R9 locked", 64'(locked), 64'(m_st == 2));
    endtask

    function automatic logic [15:0] next_lcg();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[30:15];
    endfunction

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] held;
        int base;
        rst = 1'b1; gen_en = 0; seed_load = 0; chk_en = 0;
        seed_value = '0; seed9 = '0; chk_data = '0; chk9_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(gen_data == 0 && chk_err_bits == 0, "R1 reset data", 64'({gen_data, chk_err_bits}), 64'd0);
        check(err_count == 0 && !locked, "R1 reset count/lock", 64'({err_count, locked}), 64'd0);

        // R6: garbage during fill raises nothing
        tick(0, 0, '0, 1, next_lcg());
        check(chk_err_bits == 0 && err_count == 0, "R6 fill word 1", 64'(chk_err_bits), 64'd0);
        tick(0, 0, '0, 1, next_lcg());
        check(chk_err_bits == 0 && err_count == 0, "R6 fill word 2", 64'(chk_err_bits), 64'd0);

        // R3: zero seed replaced with all ones; load beats enable
        tick(1, 1, '0, 0, '0);
        check(gen_data == 16'h0, "R3 load holds gen_data", 64'(gen_data), 64'd0);

        // clean stream: checker syncs and locks (R5, R8)
        for (int i = 0; i < 12; i++) tick(1, 0, '0, 1, gen_data);
        check(locked == 1'b1, "R8 locked after clean run", 64'(locked), 64'd1);

        // R4: hold with enable low
        held = gen_data;
        for (int i = 0; i < 3; i++) tick(0, 0, '0, 0, '0);
        check(gen_data == held, "R4 hold", 64'(gen_data), 64'(held));
        for (int i = 0; i < 3; i++) tick(1, 0, '0, 1, gen_data);
        check(chk_err_bits == 0 && locked, "R4 continues without gap", 64'(chk_err_bits), 64'd0);

        // R10: single flipped bit -> three errors, lock kept (R9)
        base = int'(err_count);
        tick(1, 0, '0, 1, gen_data ^ 16'h0400);
        for (int i = 0; i < 4; i++) tick(1, 0, '0, 1, gen_data);
        check(int'(err_count) - base == 3, "R10 three flags", 64'(int'(err_count) - base), 64'd3);
        check(locked == 1'b1, "R9 light errors keep lock", 64'(locked), 64'd1);

        // R9: fully inverted word flags every bit and drops lock
        tick(1, 0, '0, 1, ~gen_data);
        check(chk_err_bits == 16'hffff, "R9 inverted word", 64'(chk_err_bits), 64'hffff);
        check(locked == 1'b0, "R9 lock dropped", 64'(locked), 64'd0);

        // R7: garbage drives the counter to saturation
        for (int i = 0; i < 80; i++) tick(1, 0, '0, 1, next_lcg());
        check(err_count == 8'hff, "R7 saturated", 64'(err_count), 64'hff);

        // R5: relock from data alone, no reseed
        for (int i = 0; i < 12; i++) tick(1, 0, '0, 1, gen_data);
        check(locked == 1'b1, "R5 relock without seed", 64'(locked), 64'd1);
        check(err_count == 8'hff, "R7 stays saturated", 64'(err_count), 64'hff);
        check(locked9 == 1'b1, "R8 9-stage checker locked", 64'(locked9), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule